// File: doc/BRIEF.md
# Periodic ECC Memory Scrubber

This block sweeps a memory whose words carry a single-error-correcting, double-error-detecting code. It works in the background. A programmable interval timer starts a periodic sweep. The sweep always covers a fixed base region first, which is meant to hold code. It then covers every valid table entry marked for periodic scrubbing. Table entries marked for on-demand checking are swept only when a check request names them.

For each word, the scrubber reads the 39-bit codeword (32 data bits and 7 check bits) and decodes it. A single-bit upset is repaired by writing the corrected codeword back to the same address. A double-bit upset is reported with an uncorrectable flag and left in memory unchanged. Every detected upset produces a one-cycle report carrying:
- the byte address;
- the codeword bit number;
- a free-running cycle timestamp.

The normal requester shares the memory port. While a word is being read and checked, the scrubber holds the port by fixed priority. Between words it gives the port back for one cycle, so a waiting request is granted within two cycles.

Top module: `mem_scrub`

## Requirements
- R1: A periodic sweep starts every PERIOD clock cycles; with the block idle at each timer expiry, `scrub_busy` rises exactly PERIOD cycles after its previous periodic rise.
- R2: Each periodic sweep scans the base region (BASE_ADDR, BASE_LEN words) first, then each valid periodic table entry in ascending index order, with ascending word addresses inside a region.
- R3: A single-bit error in data bit i (codeword bit i, 0..31) is repaired in memory. A report follows with `rpt_uncorr`=0, `rpt_bit`=i, `rpt_byte_addr` = word address × 4, and `rpt_time` = the timestamp counter value in the cycle the word was checked. The timestamp counter is 0 at reset release and advances by one each clock.
- R4: Check-bit upsets are repaired and reported too. Codeword bit 32+k is the Hamming check bit for syndrome weight 2^k (k = 0..5). Bit 38 is the overall parity bit.
- R5: A double-bit error gives a report with `rpt_uncorr`=1 and no write to memory, so the corrupted word persists.
- R6: A valid entry whose periodic flag is 0 is not swept periodically. A `chk_req` pulse naming its index sweeps that entry once.
- R7: A `chk_req` that arrives during a periodic sweep is held and served after that sweep ends.
- R8: Between consecutive scrubbed words the port returns to the host for a cycle. A continuously requesting host never waits more than two cycles, and while granted it drives the memory address.
- R9: Entries with the valid flag 0 are never swept, so errors inside them stay unreported and uncorrected.
- R10: During and right after reset, `scrub_busy` and `rpt_valid` are 0 and a host request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Normal requester wants the port |
| host_we | input | 1 | Host write enable |
| host_addr | input | AW | Host word address |
| host_wdata | input | 39 | Host write codeword |
| host_gnt | output | 1 | Host owns the port this cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 39 | Memory write codeword |
| mem_rdata | input | 39 | Read codeword, valid the cycle after a read |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | log2(NREG) | Table entry index |
| cfg_base | input | AW | Entry start word address |
| cfg_len | input | AW | Entry length in words (0 = skip) |
| cfg_valid | input | 1 | Entry enabled |
| cfg_periodic | input | 1 | 1 = sweep every period, 0 = on request only |
| chk_req | input | 1 | Request an on-demand check |
| chk_idx | input | log2(NREG) | Entry to check |
| scrub_busy | output | 1 | A sweep is in progress |
| rpt_valid | output | 1 | Report strobe |
| rpt_uncorr | output | 1 | Report is an uncorrectable error |
| rpt_byte_addr | output | AW+2 | Byte address of the word |
| rpt_bit | output | 6 | Codeword bit that was flipped |
| rpt_time | output | TSW | Timestamp of detection |

## Verification
The bench plants upsets in data bits, in a Hamming check bit and in the overall parity bit. A decoder that mis-maps syndromes to positions would then repair the wrong bit and report a wrong bit number. A double upset checks that the decoder does not "correct" it into a third flipped bit. It also checks that the upset persists and is reported again on every sweep. Errors placed in an invalid entry and in an on-demand entry catch sweep-selection logic that ignores either flag. A request raised in the middle of a sweep shows whether it is dropped or served out of order. Throughout one sweep the host keeps requesting, which exposes a scrubber that holds the port across words.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_RD, ST_CHK, ST_GAP} scrub_st_t;

  typedef struct packed {
    logic       single;
    logic       dbl;
    logic [5:0] bitn;
  } ecc_res_t;

  // Hamming position (1-based, skipping powers of two) of data bit i.
  function automatic logic [5:0] hpos(int i);
    logic [5:0] r;
    int k;
    r = '0;
    k = 0;
    for (int p = 3; p < 39; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == i) r = p[5:0];
        k++;
      end
    end
    return r;
  endfunction

  // Check bits: [5:0] Hamming parities, [6] overall parity of the codeword.
  function automatic logic [CHK_W-1:0] ecc_gen(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    logic [5:0] pp;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pp = hpos(i);
      for (int k = 0; k < 6; k++)
        if (pp[k]) c[k] = c[k] ^ d[i];
    end
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  // Codeword bit addressed by a nonzero syndrome, 63 if none.
  function automatic logic [5:0] syn_to_bit(logic [5:0] syn);
    logic [5:0] r;
    r = 6'd63;
    for (int i = 0; i < DATA_W; i++)
      if (hpos(i) == syn) r = 6'(i);
    for (int k = 0; k < 6; k++)
      if (syn == 6'(1 << k)) r = 6'(32 + k);
    return r;
  endfunction

  function automatic ecc_res_t ecc_check(logic [CW_W-1:0] cw);
    ecc_res_t r;
    logic [CHK_W-1:0] g;
    logic [5:0] syn;
    logic [5:0] pos;
    g   = ecc_gen(cw[DATA_W-1:0]);
    syn = g[5:0] ^ cw[DATA_W+5:DATA_W];
    pos = syn_to_bit(syn);
    r   = '0;
    if (^cw) begin
      if (syn == 6'd0) begin
        r.single = 1'b1;
        r.bitn   = 6'd38;
      end else if (pos == 6'd63) begin
        r.dbl = 1'b1;
      end else begin
        r.single = 1'b1;
        r.bitn   = pos;
      end
    end else if (syn != 6'd0) begin
      r.dbl = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int PERIOD = 500_000_000,
  parameter int TSW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           tick,
  output logic [TSW-1:0] ts
);
  localparam int TCW = $clog2(PERIOD + 1);

  logic [TCW-1:0] tcnt;

  assign tick = (tcnt == TCW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      ts   <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      ts   <= ts + 1'b1;
    end
  end
endmodule

// File: rtl/scrub_regtab.sv
module scrub_regtab #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IW-1:0]            cfg_idx,
  input  logic [AW-1:0]            cfg_base,
  input  logic [AW-1:0]            cfg_len,
  input  logic                     cfg_valid,
  input  logic                     cfg_periodic,
  output logic [NREG-1:0][AW-1:0]  t_base,
  output logic [NREG-1:0][AW-1:0]  t_len,
  output logic [NREG-1:0]          t_valid,
  output logic [NREG-1:0]          t_periodic
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_base[g]     <= '0;
        t_len[g]      <= '0;
        t_valid[g]    <= 1'b0;
        t_periodic[g] <= 1'b0;
      end else if (cfg_we && cfg_idx == IW'(g)) begin
        t_base[g]     <= cfg_base;
        t_len[g]      <= cfg_len;
        t_valid[g]    <= cfg_valid;
        t_periodic[g] <= cfg_periodic;
      end
    end
  end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NREG      = 8,
  parameter int TSW       = 32,
  parameter int BASE_ADDR = 0,
  parameter int BASE_LEN  = 4096,
  localparam int IW       = $clog2(NREG),
  localparam int CURW     = $clog2(NREG + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [TSW-1:0]           ts,
  input  logic [NREG-1:0][AW-1:0]  t_base,
  input  logic [NREG-1:0][AW-1:0]  t_len,
  input  logic [NREG-1:0]          t_valid,
  input  logic [NREG-1:0]          t_periodic,
  input  logic                     chk_req,
  input  logic [IW-1:0]            chk_idx,
  input  logic [CW_W-1:0]          mem_rdata,
  output logic                     s_own,
  output logic                     s_req,
  output logic                     s_we,
  output logic [AW-1:0]            s_addr,
  output logic [CW_W-1:0]          s_wdata,
  output logic                     busy,
  output logic                     ev_double,
  output logic                     rpt_valid,
  output logic                     rpt_uncorr,
  output logic [AW+1:0]            rpt_byte_addr,
  output logic [5:0]               rpt_bit,
  output logic [TSW-1:0]           rpt_time
);
  scrub_st_t       st;
  logic            per_pend, mode_per;
  logic [NREG-1:0] dem_pend;
  logic [CURW-1:0] cur;
  logic [AW-1:0]   waddr;
  logic [AW:0]     wleft;
  logic [IW-1:0]   dem_sel, ent;
  logic            in_tab, take, ev_chk, ev_single;
  ecc_res_t        dec;

  always_comb begin
    dem_sel = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (dem_pend[i]) dem_sel = IW'(i);
  end

  assign ent    = IW'(cur - 1'b1);
  assign in_tab = (cur != '0) && (int'(cur) <= NREG);
  assign take   = in_tab && t_valid[ent] && (t_periodic[ent] || !mode_per) && (t_len[ent] != '0);

  assign dec       = ecc_check(mem_rdata);
  assign ev_chk    = (st == ST_CHK);
  assign ev_single = ev_chk && dec.single;
  assign ev_double = ev_chk && dec.dbl;

  assign busy    = (st != ST_IDLE);
  assign s_own   = (st == ST_RD) || ev_chk;
  assign s_req   = (st == ST_RD) || ev_single;
  assign s_we    = ev_single;
  assign s_addr  = waddr;
  assign s_wdata = mem_rdata ^ (CW_W'(1) << dec.bitn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; per_pend <= 1'b0; mode_per <= 1'b0; dem_pend <= '0;
      cur <= '0; waddr <= '0; wleft <= '0;
      rpt_valid <= 1'b0; rpt_uncorr <= 1'b0; rpt_byte_addr <= '0; rpt_bit <= '0; rpt_time <= '0;
    end else begin
      rpt_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (per_pend) begin
            per_pend <= 1'b0; mode_per <= 1'b1; cur <= '0; st <= ST_SEL;
          end else if (|dem_pend) begin
            dem_pend[dem_sel] <= 1'b0; mode_per <= 1'b0;
            cur <= CURW'(dem_sel) + 1'b1; st <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (cur == '0) begin
            waddr <= AW'(BASE_ADDR); wleft <= (AW+1)'(BASE_LEN); st <= ST_RD;
          end else if (take) begin
            waddr <= t_base[ent]; wleft <= {1'b0, t_len[ent]}; st <= ST_RD;
          end else if (mode_per && in_tab) begin
            cur <= cur + 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_RD: st <= ST_CHK;
        ST_CHK: begin
          if (dec.single || dec.dbl) begin
            rpt_valid     <= 1'b1;
            rpt_uncorr    <= dec.dbl;
            rpt_bit       <= dec.bitn;
            rpt_byte_addr <= {waddr, 2'b00};
            rpt_time      <= ts;
          end
          waddr <= waddr + 1'b1;
          wleft <= wleft - 1'b1;
          st    <= ST_GAP;
        end
        ST_GAP: begin
          if (wleft != '0) st <= ST_RD;
          else if (mode_per) begin
            cur <= cur + 1'b1; st <= ST_SEL;
          end else st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
      if (tick) per_pend <= 1'b1;
      if (chk_req) dem_pend[chk_idx] <= 1'b1;
    end
  end

  // R1: an expiry is never lost: it is pending or a sweep is running
  assert_tick_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (per_pend || busy));
  // R3, R4: a repaired word is reported next cycle with an in-range bit number
  assert_fix_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_single |=> (rpt_valid && !rpt_uncorr && rpt_bit <= 6'd38));
  // R3: reports only come out of a running sweep
  assert_no_idle_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rpt_valid);
  // R8: the port is released after every checked word
  assert_port_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chk |=> !s_own);
endmodule

// File: rtl/mem_scrub.sv
module mem_scrub
  import scrub_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NREG      = 8,
  parameter int PERIOD    = 500_000_000,
  parameter int TSW       = 32,
  parameter int BASE_ADDR = 0,
  parameter int BASE_LEN  = 4096,
  localparam int IW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [38:0]     host_wdata,
  output logic            host_gnt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [38:0]     mem_wdata,
  input  logic [38:0]     mem_rdata,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_len,
  input  logic            cfg_valid,
  input  logic            cfg_periodic,
  input  logic            chk_req,
  input  logic [IW-1:0]   chk_idx,
  output logic            scrub_busy,
  output logic            rpt_valid,
  output logic            rpt_uncorr,
  output logic [AW+1:0]   rpt_byte_addr,
  output logic [5:0]      rpt_bit,
  output logic [TSW-1:0]  rpt_time
);
  logic                    tick;
  logic [TSW-1:0]          ts;
  logic [NREG-1:0][AW-1:0] t_base, t_len;
  logic [NREG-1:0]         t_valid, t_periodic;
  logic                    s_own, s_req, s_we, ev_double;
  logic [AW-1:0]           s_addr;
  logic [CW_W-1:0]         s_wdata;

  scrub_timer #(.PERIOD(PERIOD), .TSW(TSW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ts(ts));

  scrub_regtab #(.AW(AW), .NREG(NREG)) u_tab (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_valid(cfg_valid),
    .cfg_periodic(cfg_periodic), .t_base(t_base), .t_len(t_len),
    .t_valid(t_valid), .t_periodic(t_periodic));

  scrub_engine #(.AW(AW), .NREG(NREG), .TSW(TSW), .BASE_ADDR(BASE_ADDR),
                 .BASE_LEN(BASE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ts(ts),
    .t_base(t_base), .t_len(t_len), .t_valid(t_valid), .t_periodic(t_periodic),
    .chk_req(chk_req), .chk_idx(chk_idx), .mem_rdata(mem_rdata),
    .s_own(s_own), .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .busy(scrub_busy), .ev_double(ev_double),
    .rpt_valid(rpt_valid), .rpt_uncorr(rpt_uncorr), .rpt_byte_addr(rpt_byte_addr),
    .rpt_bit(rpt_bit), .rpt_time(rpt_time));

  // Fixed priority: the scrubber owns the port while reading and checking a word.
  assign host_gnt  = host_req && !s_own;
  assign mem_req   = s_own ? s_req   : host_req;
  assign mem_we    = s_own ? s_we    : host_we;
  assign mem_addr  = s_own ? s_addr  : host_addr;
  assign mem_wdata = s_own ? s_wdata : host_wdata;

  // R5: an uncorrectable word is never written back
  assert_no_write_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_double |-> !mem_we);
endmodule

// File: tb/mem_scrub_tb.sv
module mem_scrub_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 10, NREG = 8, PERIOD = 2000, TSW = 32, BLEN = 16;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [38:0] host_wdata = '0;
  logic host_gnt, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [38:0] mem_wdata, mem_rdata;
  logic cfg_we = 0, cfg_valid = 0, cfg_periodic = 0;
  logic [2:0] cfg_idx = '0, chk_idx = '0;
  logic [AW-1:0] cfg_base = '0, cfg_len = '0;
  logic chk_req = 0;
  logic scrub_busy, rpt_valid, rpt_uncorr;
  logic [AW+1:0] rpt_byte_addr;
  logic [5:0] rpt_bit;
  logic [TSW-1:0] rpt_time;

  mem_scrub #(.AW(AW), .NREG(NREG), .PERIOD(PERIOD), .TSW(TSW),
              .BASE_ADDR(0), .BASE_LEN(BLEN)) u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  logic [38:0] mem [0:(1<<AW)-1];
  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else mem_rdata <= mem[mem_addr];
  end

  logic [TSW-1:0] cyc;
  always @(posedge clk or negedge rst_n) if (!rst_n) cyc <= '0; else cyc <= cyc + 1'b1;

  int nchk = 0, nfail = 0;
  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Encoder restated by walking Hamming positions
  function automatic logic [38:0] benc(logic [31:0] d);
    logic [38:1] h;
    logic [6:0] c;
    int j;
    h = '0; c = '0; j = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin h[p] = d[j]; j++; end
    for (int k = 0; k < 6; k++)
      for (int p = 1; p <= 38; p++)
        if (p[k]) c[k] = c[k] ^ h[p];
    c[6] = ^{d, c[5:0]};
    return {c, d};
  endfunction
  function automatic logic [38:0] gold(int a);
    return benc(32'h3C5A0000 ^ (a * 32'h0001_9E37));
  endfunction

  typedef struct packed { logic [AW+1:0] a; logic [5:0] b; logic u; } exp_t;
  exp_t q[$];
  task automatic expect_rpt(int wa, int b, bit u);
    q.push_back('{a: (AW+2)'(wa * 4), b: 6'(b), u: u});
  endtask

  // Monitor / scoreboard
  always @(negedge clk) if (rst_n && rpt_valid) begin
    if (q.size() == 0) check(0, "R9", "unexpected report addr", rpt_byte_addr, 0);
    else begin
      exp_t e;
      e = q.pop_front();
      check(rpt_byte_addr == e.a, "R3", "report byte address", rpt_byte_addr, e.a);
      check(rpt_uncorr == e.u, "R5", "uncorrectable flag", rpt_uncorr, e.u);
      if (!e.u) check(rpt_bit == e.b, "R4", "report bit number", rpt_bit, e.b);
      check(rpt_time == cyc - 1, "R3", "timestamp", rpt_time, cyc - 1);
    end
  end

  // Host latency monitor for R8
  int hwait = 0, hmax = 0, hgrants = 0, hbad = 0;
  always @(negedge clk) if (rst_n && host_req) begin
    if (host_gnt) begin
      hwait = 0; hgrants++;
      if (mem_addr != host_addr) hbad++;
    end else begin
      hwait++; if (hwait > hmax) hmax = hwait;
    end
  end

  task automatic cfg(int i, int b, int l, bit v, bit p);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_base = AW'(b); cfg_len = AW'(l); cfg_valid = v; cfg_periodic = p;
    @(negedge clk);
    cfg_we = 0;
  endtask
  task automatic wait_rise(output longint t);
    @(negedge clk);
    while (scrub_busy) @(negedge clk);
    while (!scrub_busy) @(negedge clk);
    t = longint'(cyc);
  endtask
  task automatic wait_fall();
    while (scrub_busy) @(negedge clk);
  endtask
  task automatic flip(int a, int b);
    mem[a] = gold(a) ^ (39'd1 << b);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint r1, r2, r3, rd;
    for (int a = 0; a < (1 << AW); a++) mem[a] = gold(a);
    host_req = 1;
    repeat (3) @(negedge clk);
    check(scrub_busy == 0, "R10", "busy in reset", scrub_busy, 0);
    check(rpt_valid == 0, "R10", "report in reset", rpt_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(host_gnt == 1, "R10", "host grant after reset", host_gnt, 1);
    host_req = 0;
    cfg(0, 100, 8, 1, 1);
    cfg(1, 200, 4, 1, 0);
    cfg(2, 300, 4, 0, 1);
    cfg(3, 400, 4, 1, 1);

    wait_rise(r1); wait_fall();                  // clean sweep, no reports
    flip(3, 5); flip(5, 38); flip(102, 34);      // R2 order: base, then entries
    mem[401] = gold(401) ^ 39'h81;               // double
    flip(201, 10); flip(301, 3);                 // demand-only and invalid
    expect_rpt(3, 5, 0); expect_rpt(5, 38, 0); expect_rpt(102, 34, 0); expect_rpt(401, 0, 1);
    host_addr = AW'(600); host_req = 1; hmax = 0; hgrants = 0;
    wait_rise(r2);
    check(r2 - r1 == PERIOD, "R1", "period between sweeps", r2 - r1, PERIOD);
    wait_fall();
    host_req = 0;
    @(negedge clk);
    check(hmax <= 2, "R8", "max host wait", hmax, 2);
    check(hgrants > 0 && hbad == 0, "R8", "host granted with its address", hbad, 0);
    check(mem[3] == gold(3), "R3", "data bit repaired", mem[3], gold(3));
    check(mem[5] == gold(5), "R4", "parity bit repaired", mem[5], gold(5));
    check(mem[102] == gold(102), "R4", "check bit repaired", mem[102], gold(102));
    check(mem[401] == (gold(401) ^ 39'h81), "R5", "double left intact", mem[401], gold(401) ^ 39'h81);
    check(mem[201] == (gold(201) ^ (39'd1 << 10)), "R6", "demand entry untouched", mem[201], gold(201) ^ (39'd1 << 10));
    check(mem[301] == (gold(301) ^ 39'd8), "R9", "invalid entry untouched", mem[301], gold(301) ^ 39'd8);
    check(q.size() == 0, "R2", "periodic reports outstanding", q.size(), 0);

    expect_rpt(201, 10, 0);
    @(negedge clk); chk_req = 1; chk_idx = 3'd1;
    @(negedge clk); chk_req = 0;
    while (!scrub_busy) @(negedge clk);
    wait_fall();
    @(negedge clk);
    check(mem[201] == gold(201), "R6", "demand entry repaired", mem[201], gold(201));
    check(q.size() == 0, "R6", "demand report outstanding", q.size(), 0);

    flip(7, 1); flip(202, 0);
    expect_rpt(7, 1, 0); expect_rpt(401, 0, 1); expect_rpt(202, 0, 0);  // R7 order
    wait_rise(r3);
    check(r3 - r2 == PERIOD, "R1", "period with demand sweep between", r3 - r2, PERIOD);
    chk_req = 1; chk_idx = 3'd1;
    @(negedge clk); chk_req = 0;
    rd = 0;
    while (q.size() != 0 && rd < 2000) begin @(negedge clk); rd++; end
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R7", "queued demand served", q.size(), 0);
    check(mem[202] == gold(202), "R7", "queued demand repaired", mem[202], gold(202));
    check(mem[7] == gold(7), "R3", "base word repaired", mem[7], gold(7));
    check(scrub_busy == 0, "R7", "idle after queued demand", scrub_busy, 0);
    finish_run();
  end
endmodule